// File: doc/BRIEF.md
# Multiplexed Expansion Bus to SRAM Demultiplexer

This block connects a microcontroller expansion bus, where address and data share the same pins, to an asynchronous 16-bit SRAM. Each bus cycle has two halves, marked by the bus clock E. While E is low the two 8-bit ports carry the address. While E is high they carry data. The block samples E on a fast system clock. It holds the address that was present while E was low and drives it to the SRAM for the rest of the cycle. From E, the read/write line and the low-byte strobe it produces the chip select, the output enable and one write enable per byte lane. It also steers write data to the SRAM lanes and drives read data back onto the ports.

A mode input selects a wide bus or a narrow bus. On a wide bus port A carries the upper byte and port B the lower byte of both address and data. On a narrow bus only port A carries data. The SRAM is treated as two byte lanes: even addresses use the upper lane and odd addresses use the lower lane. The SRAM occupies the half of the address space picked by a parameter, which by default is the lower half (address bit 15 equal to 0). All enables are active low.

Top module: `mbx_demux`

## Requirements
- R1: On every clock edge where `e_clk` is sampled low, the held address is loaded with {`port_a_in`, `port_b_in`}. While `e_clk` is high it keeps the last value loaded. `mem_addr` shows the held address.
- R2: `mem_cs_n` is 0 only when `e_clk` is high, an address phase has been seen since reset, and held address bit 15 is 0. Otherwise it is 1.
- R3: `mem_oe_n` is 0 only when `e_clk` is high, `rw_n` is 1 (read), and an address phase has been seen since reset. It does not depend on address bit 15.
- R4: Wide mode (`wide_mode`=1) write, where `rw_n`=0 and `e_clk` is high:
  - If held address bit 0 is 1, only `mem_we_lo_n` goes to 0, whatever `lstrb_n` is.
  - If bit 0 is 0 and `lstrb_n` is 0, both write enables go to 0.
  - If bit 0 is 0 and `lstrb_n` is 1, only `mem_we_hi_n` goes to 0.
- R5: Narrow mode (`wide_mode`=0) write: bit 0 equal to 0 lowers only `mem_we_hi_n`, and bit 0 equal to 1 lowers only `mem_we_lo_n`. `lstrb_n` has no effect.
- R6: Write data on `mem_wdata`. In wide mode, bits 15:8 are `port_a_in` and bits 7:0 are `port_b_in`. In narrow mode, `port_a_in` is copied onto both byte lanes.
- R7: Read return, while `mem_oe_n` is 0:
  - `port_a_drive` is 1.
  - In wide mode, `port_b_drive` is 1, `port_a_out` = `mem_rdata`[15:8] and `port_b_out` = `mem_rdata`[7:0].
  - In narrow mode, `port_b_drive` is 0, and `port_a_out` is `mem_rdata`[15:8] for an even address and `mem_rdata`[7:0] for an odd address.
  - While `mem_oe_n` is 1, both drive flags are 0.
- R8: During reset, and after reset until the first clock edge with `e_clk` low, all four enables are 1 and both drive flags are 0, whatever `e_clk` and `rw_n` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous reset, active high |
| e_clk | input | 1 | Bus clock: low is the address phase, high is the data phase |
| rw_n | input | 1 | 1 = read, 0 = write |
| lstrb_n | input | 1 | Low-byte strobe, active low |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| port_a_in | input | 8 | Upper port, value seen on the bus |
| port_b_in | input | 8 | Lower port, value seen on the bus |
| port_a_out | output | 8 | Read data for the upper port |
| port_b_out | output | 8 | Read data for the lower port |
| port_a_drive | output | 1 | Drive enable for the upper port; 0 means high impedance |
| port_b_drive | output | 1 | Drive enable for the lower port; 0 means high impedance |
| mem_addr | output | 16 | Held (demultiplexed) address |
| mem_cs_n | output | 1 | SRAM chip select, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_hi_n | output | 1 | Write enable for SRAM bits 15:8, active low |
| mem_we_lo_n | output | 1 | Write enable for SRAM bits 7:0, active low |
| mem_wdata | output | 16 | Write data to the SRAM |
| mem_rdata | input | 16 | Read data from the SRAM |

## Verification
The bench checks odd-address writes with the strobe both asserted and negated. A design that lets the strobe take priority over address bit 0 would write the upper lane or both lanes. It repeats narrow writes with the strobe toggled, which catches logic that treats a narrow cycle as a word write. It also checks the lane that a narrow read returns on an even and an odd address, which catches a swapped lane mux. The remaining directed tests cover three cases:
- A data phase held over several clocks while the ports change. This catches an address register that keeps following the bus.
- A read from the upper half of the address space. This catches an output enable wrongly gated by chip select.
- A data phase that arrives straight out of reset. This catches enables that fire before any address phase has been seen.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic {
      BUS_NARROW = 1'b0,
      BUS_WIDE   = 1'b1
   } bus_mode_e;

   // Internal strobes, active high; the top inverts them for the pins
   typedef struct packed {
      logic cs;
      logic oe;
      logic we_hi;
      logic we_lo;
   } strobe_t;

   // Byte-lane write mask {upper, lower}.
   // Wide mode: an odd address selects the lower lane only; otherwise the
   // strobe picks a word write or an upper-lane write.
   // Narrow mode: address bit 0 alone picks the lane.
   function automatic logic [1:0] lane_mask(input bus_mode_e mode,
                                            input logic      a_lsb,
                                            input logic      lstrb_n);
      logic [1:0] m;
      if (mode == BUS_WIDE) begin
         if (a_lsb)         m = 2'b01;
         else if (!lstrb_n) m = 2'b11;
         else               m = 2'b10;
      end else begin
         m = a_lsb ? 2'b01 : 2'b10;
      end
      return m;
   endfunction

endpackage

// File: rtl/mbx_addr_latch.sv
module mbx_addr_latch #(
   parameter int LANE_W = 8,
   parameter int ADDR_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              e_clk,
   input  logic [LANE_W-1:0] hi_in,
   input  logic [LANE_W-1:0] lo_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic              phase_seen
);

   localparam int CAT_W = 2 * LANE_W;

   if (CAT_W != ADDR_W) begin : g_bad_width
      $error("mbx_addr_latch: address width must equal two lanes");
   end

   logic [CAT_W-1:0] bus_word;
   assign bus_word = {hi_in, lo_in};

   // Address phase: follow the bus while E is low, hold while E is high
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (!e_clk) begin
         addr_q <= bus_word;
      end
   end

   // Set once a full address phase has been sampled after reset
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_seen <= 1'b0;
      end else if (!e_clk) begin
         phase_seen <= 1'b1;
      end
   end

endmodule

// File: rtl/mbx_strobe_gen.sv
module mbx_strobe_gen
   import mbx_pkg::*;
#(
   parameter bit SEL_UPPER = 1'b0
) (
   input  logic      e_clk,
   input  logic      rw_n,
   input  logic      lstrb_n,
   input  bus_mode_e mode,
   input  logic      phase_seen,
   input  logic      addr_sel,
   input  logic      addr_lsb,
   output strobe_t   strb
);

   logic       active;
   logic       sel_hit;
   logic [1:0] mask;

   assign active = e_clk & phase_seen;

   // Which half of the address space the SRAM answers in
   if (SEL_UPPER) begin : g_sel_upper
      assign sel_hit = addr_sel;
   end else begin : g_sel_lower
      assign sel_hit = ~addr_sel;
   end

   assign mask = lane_mask(mode, addr_lsb, lstrb_n);

   always_comb begin
      strb.cs    = active & sel_hit;
      strb.oe    = active & rw_n;
      strb.we_hi = active & ~rw_n & mask[1];
      strb.we_lo = active & ~rw_n & mask[0];
   end

endmodule

// File: rtl/mbx_data_steer.sv
module mbx_data_steer
   import mbx_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  bus_mode_e                mode,
   input  logic                     addr_lsb,
   input  logic                     rd_active,
   input  logic [LANE_W-1:0]        hi_in,
   input  logic [LANE_W-1:0]        lo_in,
   input  logic [LANES*LANE_W-1:0]  rdata,
   output logic [LANES*LANE_W-1:0]  wdata,
   output logic [LANE_W-1:0]        hi_out,
   output logic [LANE_W-1:0]        lo_out,
   output logic                     hi_drive,
   output logic                     lo_drive
);

   localparam int WORD_W = LANES * LANE_W;
   localparam int HI_LSB = (LANES - 1) * LANE_W;

   if (LANES != 2) begin : g_bad_lanes
      $error("mbx_data_steer: exactly two byte lanes are supported");
   end

   logic [WORD_W-1:0] wide_word;
   assign wide_word = {hi_in, lo_in};

   // Write path: per-lane choice between the wide word and the narrow byte
   for (genvar i = 0; i < LANES; i++) begin : g_wlane
      assign wdata[i*LANE_W +: LANE_W] =
         (mode == BUS_WIDE) ? wide_word[i*LANE_W +: LANE_W] : hi_in;
   end

   logic [LANE_W-1:0] rd_hi_lane;
   logic [LANE_W-1:0] rd_lo_lane;
   assign rd_hi_lane = rdata[HI_LSB +: LANE_W];
   assign rd_lo_lane = rdata[0 +: LANE_W];

   // Read path: narrow bus returns the lane addressed by bit 0
   always_comb begin
      if (mode == BUS_WIDE || !addr_lsb) begin
         hi_out = rd_hi_lane;
      end else begin
         hi_out = rd_lo_lane;
      end
      lo_out   = rd_lo_lane;
      hi_drive = rd_active;
      lo_drive = rd_active & (mode == BUS_WIDE);
   end

endmodule

// File: rtl/mbx_demux.sv
module mbx_demux
   import mbx_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int SEL_BIT   = ADDR_W - 1,
   parameter bit SEL_UPPER = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                e_clk,
   input  logic                rw_n,
   input  logic                lstrb_n,
   input  logic                wide_mode,
   input  logic [LANE_W-1:0]   port_a_in,
   input  logic [LANE_W-1:0]   port_b_in,
   output logic [LANE_W-1:0]   port_a_out,
   output logic [LANE_W-1:0]   port_b_out,
   output logic                port_a_drive,
   output logic                port_b_drive,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_cs_n,
   output logic                mem_oe_n,
   output logic                mem_we_hi_n,
   output logic                mem_we_lo_n,
   output logic [2*LANE_W-1:0] mem_wdata,
   input  logic [2*LANE_W-1:0] mem_rdata
);

   localparam int LANES = 2;

   if (ADDR_W != LANES * LANE_W) begin : g_chk_addr_w
      $error("mbx_demux: ADDR_W must be twice LANE_W");
   end
   if (SEL_BIT < 1 || SEL_BIT >= ADDR_W) begin : g_chk_sel
      $error("mbx_demux: SEL_BIT out of range");
   end
   if (LANE_W < 1) begin : g_chk_lane
      $error("mbx_demux: LANE_W must be positive");
   end

   bus_mode_e mode;
   assign mode = wide_mode ? BUS_WIDE : BUS_NARROW;

   logic [ADDR_W-1:0] addr_q;
   logic              phase_seen;
   strobe_t           strb;

   mbx_addr_latch #(
      .LANE_W (LANE_W),
      .ADDR_W (ADDR_W)
   ) u_latch (
      .clk        (clk),
      .rst        (rst),
      .e_clk      (e_clk),
      .hi_in      (port_a_in),
      .lo_in      (port_b_in),
      .addr_q     (addr_q),
      .phase_seen (phase_seen)
   );

   mbx_strobe_gen #(
      .SEL_UPPER (SEL_UPPER)
   ) u_strobe (
      .e_clk      (e_clk),
      .rw_n       (rw_n),
      .lstrb_n    (lstrb_n),
      .mode       (mode),
      .phase_seen (phase_seen),
      .addr_sel   (addr_q[SEL_BIT]),
      .addr_lsb   (addr_q[0]),
      .strb       (strb)
   );

   mbx_data_steer #(
      .LANE_W (LANE_W),
      .LANES  (LANES)
   ) u_steer (
      .mode      (mode),
      .addr_lsb  (addr_q[0]),
      .rd_active (strb.oe),
      .hi_in     (port_a_in),
      .lo_in     (port_b_in),
      .rdata     (mem_rdata),
      .wdata     (mem_wdata),
      .hi_out    (port_a_out),
      .lo_out    (port_b_out),
      .hi_drive  (port_a_drive),
      .lo_drive  (port_b_drive)
   );

   assign mem_addr    = addr_q;
   assign mem_cs_n    = ~strb.cs;
   assign mem_oe_n    = ~strb.oe;
   assign mem_we_hi_n = ~strb.we_hi;
   assign mem_we_lo_n = ~strb.we_lo;

endmodule

// File: rtl/mbx_demux_chk.sv
module mbx_demux_chk #(
   parameter int ADDR_W    = 16,
   parameter int SEL_BIT   = ADDR_W - 1,
   parameter bit SEL_UPPER = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              e_clk,
   input logic              rw_n,
   input logic              wide_mode,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_hi_n,
   input logic              mem_we_lo_n,
   input logic              port_a_drive,
   input logic              port_b_drive
);

   // Checker-side record of whether an address phase has occurred
   logic seen_low;
   always_ff @(posedge clk) begin
      if (rst)         seen_low <= 1'b0;
      else if (!e_clk) seen_low <= 1'b1;
   end

   // R1: address held through the data phase
   a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(e_clk) && !$past(rst)) |-> $stable(mem_addr));

   // R2: chip select only in data phase and matching half
   a_r2_cs_needs_e: assert property (@(posedge clk) disable iff (rst)
      !e_clk |-> mem_cs_n);
   a_r2_cs_half: assert property (@(posedge clk) disable iff (rst)
      !mem_cs_n |-> (mem_addr[SEL_BIT] == SEL_UPPER));

   // R3: output enable only on a read data phase
   a_r3_oe_read: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (rw_n && e_clk));

   // R4: no write strobe during a read
   a_r4_no_we_on_read: assert property (@(posedge clk) disable iff (rst)
      rw_n |-> (mem_we_hi_n && mem_we_lo_n));

   // R5: narrow bus never writes both lanes
   a_r5_narrow_one_lane: assert property (@(posedge clk) disable iff (rst)
      !wide_mode |-> (mem_we_hi_n || mem_we_lo_n));

   // R7: ports are driven exactly while the SRAM output is enabled
   a_r7_drive_oe: assert property (@(posedge clk) disable iff (rst)
      port_a_drive == !mem_oe_n);
   a_r7_narrow_b_quiet: assert property (@(posedge clk) disable iff (rst)
      !wide_mode |-> !port_b_drive);

   // R8: everything idle before the first address phase
   a_r8_quiet_start: assert property (@(posedge clk) disable iff (rst)
      !seen_low |-> (mem_cs_n && mem_oe_n && mem_we_hi_n && mem_we_lo_n
                     && !port_a_drive && !port_b_drive));

endmodule

bind mbx_demux mbx_demux_chk #(
   .ADDR_W    (ADDR_W),
   .SEL_BIT   (SEL_BIT),
   .SEL_UPPER (SEL_UPPER)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .e_clk        (e_clk),
   .rw_n         (rw_n),
   .wide_mode    (wide_mode),
   .mem_addr     (mem_addr),
   .mem_cs_n     (mem_cs_n),
   .mem_oe_n     (mem_oe_n),
   .mem_we_hi_n  (mem_we_hi_n),
   .mem_we_lo_n  (mem_we_lo_n),
   .port_a_drive (port_a_drive),
   .port_b_drive (port_b_drive)
);

// File: tb/test_mbx_demux.sv
module test_mbx_demux;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        e_clk = 1'b1;
   logic        rw_n = 1'b0;
   logic        lstrb_n = 1'b1;
   logic        wide_mode = 1'b1;
   logic [7:0]  port_a_in = 8'h00;
   logic [7:0]  port_b_in = 8'h00;
   logic [7:0]  port_a_out;
   logic [7:0]  port_b_out;
   logic        port_a_drive;
   logic        port_b_drive;
   logic [15:0] mem_addr;
   logic        mem_cs_n;
   logic        mem_oe_n;
   logic        mem_we_hi_n;
   logic        mem_we_lo_n;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = 16'h0000;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   mbx_demux i_mbx_demux (
      .clk (clk), .rst (rst), .e_clk (e_clk), .rw_n (rw_n),
      .lstrb_n (lstrb_n), .wide_mode (wide_mode),
      .port_a_in (port_a_in), .port_b_in (port_b_in),
      .port_a_out (port_a_out), .port_b_out (port_b_out),
      .port_a_drive (port_a_drive), .port_b_drive (port_b_drive),
      .mem_addr (mem_addr), .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n),
      .mem_we_hi_n (mem_we_hi_n), .mem_we_lo_n (mem_we_lo_n),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // en = {cs_n, oe_n, we_hi_n, we_lo_n}
   typedef struct packed {
      logic        wide;
      logic        rd;
      logic        lstrb_n;
      logic [15:0] addr;
      logic [15:0] wdat;
      logic [15:0] rdat;
      logic [3:0]  en;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 1'b0, 1'b0, 16'h1234, 16'hA55A, 16'h0000, 4'b0100}, // word write
      '{1'b1, 1'b0, 1'b0, 16'h1235, 16'h3C7E, 16'h0000, 4'b0110}, // odd, strobe low
      '{1'b1, 1'b0, 1'b1, 16'h2000, 16'h9911, 16'h0000, 4'b0101}, // upper only
      '{1'b1, 1'b1, 1'b1, 16'h0042, 16'h0000, 16'hBEEF, 4'b0011}, // wide read
      '{1'b1, 1'b0, 1'b0, 16'h8000, 16'h1357, 16'h0000, 4'b1100}, // upper half
      '{1'b0, 1'b0, 1'b1, 16'h0100, 16'h6D00, 16'h0000, 4'b0101}, // narrow even
      '{1'b0, 1'b0, 1'b0, 16'h0101, 16'h2400, 16'h0000, 4'b0110}, // narrow odd
      '{1'b0, 1'b0, 1'b0, 16'h0100, 16'hC300, 16'h0000, 4'b0101}, // strobe ignored
      '{1'b0, 1'b1, 1'b0, 16'h0301, 16'h0000, 16'h12F0, 4'b0011}, // narrow odd read
      '{1'b0, 1'b1, 1'b1, 16'h0300, 16'h0000, 16'h12F0, 4'b0011}, // narrow even read
      '{1'b1, 1'b1, 1'b0, 16'h9000, 16'h0000, 16'h7777, 4'b1011}, // read upper half
      '{1'b1, 1'b0, 1'b1, 16'h4001, 16'h5A00, 16'h0000, 4'b0110}  // odd, strobe high
   };

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R8: under reset, data-phase stimulus must not raise any enable
      repeat (3) @(negedge clk);
      #1;
      chk("R8 enables in reset", {mem_cs_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n}, 4'b1111);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R8 enables before addr phase", {mem_cs_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n}, 4'b1111);
      rw_n = 1'b1;
      #1;
      chk("R8 no drive before addr phase", {30'd0, port_a_drive, port_b_drive}, 0);
      chk("R8 oe before addr phase", mem_oe_n, 1);

      // R2/R3: E low phase keeps all enables inactive
      @(negedge clk);
      e_clk = 1'b0; rw_n = 1'b0; port_a_in = 8'h00; port_b_in = 8'h10;
      #1;
      chk("R2 R3 enables while E low", {mem_cs_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n}, 4'b1111);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         e_clk = 1'b0;
         rw_n = 1'b1;
         wide_mode = VEC[i].wide;
         lstrb_n = VEC[i].lstrb_n;
         port_a_in = VEC[i].addr[15:8];
         port_b_in = VEC[i].addr[7:0];
         @(negedge clk);
         e_clk = 1'b1;
         rw_n = VEC[i].rd;
         port_a_in = VEC[i].wdat[15:8];
         port_b_in = VEC[i].wdat[7:0];
         mem_rdata = VEC[i].rdat;
         #1;
         chk(VEC[i].wide ? "R4 R2 R3 enables" : "R5 R2 R3 enables",
             {mem_cs_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n}, VEC[i].en);
         chk("R1 held address", mem_addr, VEC[i].addr);
         if (!VEC[i].rd) begin
            chk("R6 write data", mem_wdata,
                VEC[i].wide ? VEC[i].wdat : {VEC[i].wdat[15:8], VEC[i].wdat[15:8]});
            chk("R7 no drive on write", {port_a_drive, port_b_drive}, 2'b00);
         end else if (VEC[i].wide) begin
            chk("R7 wide drive", {port_a_drive, port_b_drive}, 2'b11);
            chk("R7 wide read data", {port_a_out, port_b_out}, VEC[i].rdat);
         end else begin
            chk("R7 narrow drive", {port_a_drive, port_b_drive}, 2'b10);
            chk("R7 narrow read lane", port_a_out,
                VEC[i].addr[0] ? VEC[i].rdat[7:0] : VEC[i].rdat[15:8]);
         end
      end

      // R1: long data phase with the ports changing every clock
      @(negedge clk);
      e_clk = 1'b0; rw_n = 1'b1; wide_mode = 1'b1;
      port_a_in = 8'h0A; port_b_in = 8'hBC;
      @(negedge clk);
      e_clk = 1'b1;
      for (int k = 0; k < 3; k++) begin
         port_a_in = 8'(k * 17 + 3); port_b_in = 8'(k * 29 + 5);
         @(negedge clk);
         #1;
         chk("R1 address held over long data phase", mem_addr, 16'h0ABC);
      end

      // R8: reset in mid-cycle returns to the quiet state
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; e_clk = 1'b1; rw_n = 1'b0;
      #1;
      chk("R8 quiet after mid reset", {mem_cs_n, mem_oe_n, mem_we_hi_n, mem_we_lo_n}, 4'b1111);
      rw_n = 1'b1;
      #1;
      chk("R8 no drive after mid reset", {port_a_drive, port_b_drive}, 2'b00);
      @(negedge clk);
      #1;
      chk("R8 still quiet with E held high", mem_oe_n, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule